// File: doc/BRIEF.md
# Password-Gated Sector Memory Slave

This block is the protocol core of a two-wire serial memory slave. It keeps a small byte array behind a pair of 8-byte passwords. A separate bus front end turns the raw clock and data line activity into single-cycle event strobes: a start event, a stop event, a received byte with its value, and a request for the next byte during a read. This core decides whether each received byte is acknowledged. It also presents the byte the front end shifts out during a read.

Every access follows the same sequence. The master sends a start and a command byte, followed by eight password bytes. It then issues a repeated start and one poll byte. The poll byte is acknowledged only if the password matched, and only then does data move. Reads begin at the first byte of the addressed sector and may run on without limit, wrapping at the end of the array. Writes collect exactly eight bytes. After the closing stop, the block enters a fixed-length busy period, and the buffered sector is committed at the end of that period.

There are nine states. IDLE is standby. CMD waits for the command byte. PWD collects the password. POLL waits for the polling start. CHK judges the poll byte. READ streams data out. WRITE collects data in. BUSY is the nonvolatile write period. REJECT refuses every byte until a stop arrives.

The transitions are:
- IDLE goes to CMD on a start.
- CMD goes to PWD on an accepted command, or to REJECT on a bad sector.
- PWD goes to POLL after the eighth password byte.
- POLL goes to CHK on a start.
- CHK goes to READ or WRITE on a match, or to REJECT on a mismatch.
- A start in PWD, READ or WRITE returns to CMD.
- A stop in WRITE with eight bytes goes to BUSY.
- BUSY goes to IDLE when the timer expires.
- Any other stop outside BUSY goes to IDLE.

Top module: `pwmem_slave`

## Requirements
- R1: After reset, ack_ok and tx_valid are 0, tx_data is 0, and every array byte reads back as 0x00.
- R2: The command byte is decoded as follows. Bit 7 = 1 selects a read and 0 selects a write. Bit 6 selects password B (1) or password A (0). Bits 5:0 give the sector. Sectors 0..13 are acknowledged. A sector value of 14 or more is not acknowledged, and every further byte is also refused until a stop.
- R3: The eight bytes after an accepted command are each acknowledged, whatever their value. Both passwords default to all zeros.
- R4: After the eighth password byte, a byte sent without a repeated start is not acknowledged. After a repeated start, the next byte (the poll byte) is acknowledged if the password matched, and the data phase then begins.
- R5: If any password byte differs from the selected password, the poll byte and all later bytes are not acknowledged and no read data is presented. A stop returns the block to standby, and a following correct transaction succeeds.
- R6: A read presents tx_valid = 1. tx_data starts with byte 8*sector of the array. Each rd_next pulse advances tx_data to the next byte, with the new value visible one cycle later.
- R7: A read that reaches byte 111 continues at byte 0.
- R8: A write acknowledges exactly eight data bytes; the first goes to the sector's byte 0. A ninth byte is not acknowledged, and the write is discarded.
- R9: A stop after fewer than eight write bytes discards the write and returns the block to standby at once, with no busy period.
- R10: A stop after eight write bytes starts a busy period of WR_CYCLES cycles. In that period any byte, including a command byte, is not acknowledged. At its end the eight bytes are committed to the sector.
- R11: A start during PWD, READ or WRITE abandons the current access, discards any partial write, and makes the next byte a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_start | input | 1 | Start event strobe from the bus front end |
| in_stop | input | 1 | Stop event strobe from the bus front end |
| in_byte_valid | input | 1 | A byte has been received from the master |
| in_byte | input | 8 | Value of the received byte |
| in_rd_next | input | 1 | The master acknowledged the read byte and wants the next one |
| ack_ok | output | 1 | Acknowledge decision for the last received byte (1 = drive ACK) |
| tx_valid | output | 1 | Read data phase active |
| tx_data | output | 8 | Byte to shift out during a read |

## Verification
The bench writes distinct patterns to all fourteen sectors, alternating between the two passwords, and reads every sector back. This catches an off-by-one in the sector base, a swapped byte order, and a commit that lands in the wrong sector. A read run through sector 13 into sector 0 exposes a pointer that runs past the array instead of wrapping. Probes during the busy period, short writes, a ninth write byte, and starts in the middle of an access each check both the acknowledge answer and the array contents afterwards. A design that committed early, accepted a partial or oversized write, or kept an abandoned buffer would therefore show changed data. The wrong-password, missing-poll-start and out-of-range-sector cases check that the refusal persists until a stop and then clears.

// File: rtl/pwmem_pkg.sv
package pwmem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_PWD,
        ST_POLL,
        ST_CHK,
        ST_READ,
        ST_WRITE,
        ST_BUSY,
        ST_REJECT
    } pw_state_e;

endpackage

// File: rtl/pwmem_array.sv
module pwmem_array #(
    parameter int SECTORS    = 14,
    parameter int SECT_BYTES = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [$clog2(SECTORS*SECT_BYTES)-1:0]    rd_addr,
    output logic [7:0]                               rd_data,
    input  logic                                     wr_en,
    input  logic [$clog2(SECTORS)-1:0]               wr_sector,
    input  logic [SECT_BYTES*8-1:0]                  wr_data
);
    localparam int DEPTH = SECTORS * SECT_BYTES;
    localparam int SW    = $clog2(SECTORS);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < DEPTH; g++) mem[g] <= '0;
        end else if (wr_en) begin
            for (int g = 0; g < DEPTH; g++) begin
                if (wr_sector == SW'(g / SECT_BYTES))
                    mem[g] <= wr_data[(g % SECT_BYTES)*8 +: 8];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < DEPTH; g++) begin
            if (int'(rd_addr) == g) rd_data = mem[g];
        end
    end

endmodule

// File: rtl/pwmem_pwd_chk.sv
module pwmem_pwd_chk #(
    parameter int                    PWD_BYTES = 8,
    parameter logic [PWD_BYTES*8-1:0] PWD_A    = '0,
    parameter logic [PWD_BYTES*8-1:0] PWD_B    = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          sel_b,
    input  logic                          byte_v,
    input  logic [7:0]                    byte_in,
    input  logic [$clog2(PWD_BYTES)-1:0]  idx,
    output logic                          match
);
    localparam int PCW = $clog2(PWD_BYTES);

    logic       bad_q;
    logic [7:0] exp_b;

    // first byte on the wire is the most significant password byte
    always_comb begin
        exp_b = '0;
        for (int k = 0; k < PWD_BYTES; k++) begin
            if (idx == PCW'(k))
                exp_b = sel_b ? PWD_B[(PWD_BYTES-1-k)*8 +: 8]
                              : PWD_A[(PWD_BYTES-1-k)*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          bad_q <= 1'b0;
        else if (clear)                      bad_q <= 1'b0;
        else if (byte_v && byte_in != exp_b) bad_q <= 1'b1;
    end

    assign match = !bad_q;

endmodule

// File: rtl/pwmem_busy_tmr.sv
module pwmem_busy_tmr #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= TW'(CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run_q && (cnt_q == '0);

endmodule

// File: rtl/pwmem_slave.sv
module pwmem_slave
    import pwmem_pkg::*;
#(
    parameter int                     SECTORS    = 14,
    parameter int                     SECT_BYTES = 8,
    parameter int                     PWD_BYTES  = 8,
    parameter int                     WR_CYCLES  = 16,
    parameter logic [PWD_BYTES*8-1:0] PWD_A      = '0,
    parameter logic [PWD_BYTES*8-1:0] PWD_B      = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_start,
    input  logic       in_stop,
    input  logic       in_byte_valid,
    input  logic [7:0] in_byte,
    input  logic       in_rd_next,
    output logic       ack_ok,
    output logic       tx_valid,
    output logic [7:0] tx_data
);
    localparam int DEPTH = SECTORS * SECT_BYTES;
    localparam int AW    = $clog2(DEPTH);
    localparam int SW    = $clog2(SECTORS);
    localparam int PCW   = $clog2(PWD_BYTES);
    localparam int CW    = $clog2(SECT_BYTES + 1);

    pw_state_e st, st_nx;

    logic                    cmd_rd_q, cmd_sel_q;
    logic [SW-1:0]           sector_q;
    logic [PCW-1:0]          pcnt_q;
    logic [CW-1:0]           wcnt_q;
    logic [SECT_BYTES*8-1:0] wbuf_q;
    logic [AW-1:0]           rd_ptr;
    logic [7:0]              rd_data;

    logic byte_ev, rd_adv, ack_nx, sector_ok, wr_full;
    logic pwd_match, pwd_clear, pwd_byte;
    logic tmr_load, tmr_done, commit;

    assign byte_ev   = in_byte_valid && !in_start && !in_stop;
    assign rd_adv    = in_rd_next && !in_start && !in_stop && (st == ST_READ);
    assign sector_ok = int'(in_byte[5:0]) < SECTORS;
    assign wr_full   = (wcnt_q == CW'(SECT_BYTES));
    assign pwd_clear = (st == ST_CMD) && byte_ev;
    assign pwd_byte  = (st == ST_PWD) && byte_ev;
    assign tmr_load  = (st == ST_WRITE) && in_stop && wr_full;
    assign commit    = (st == ST_BUSY) && tmr_done;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // ---------------- next state and ACK decision ----------------
    always_comb begin
        st_nx  = st;
        ack_nx = 1'b0;
        if (st == ST_BUSY) begin
            if (tmr_done) st_nx = ST_IDLE;
        end else if (in_stop) begin
            st_nx = (st == ST_WRITE && wr_full) ? ST_BUSY : ST_IDLE;
        end else if (in_start) begin
            unique case (st)
                ST_POLL, ST_CHK: st_nx = ST_CHK;
                ST_REJECT:       st_nx = ST_REJECT;
                default:         st_nx = ST_CMD;
            endcase
        end else if (byte_ev) begin
            unique case (st)
                ST_CMD: begin
                    ack_nx = sector_ok;
                    st_nx  = sector_ok ? ST_PWD : ST_REJECT;
                end
                ST_PWD: begin
                    ack_nx = 1'b1;
                    if (pcnt_q == PCW'(PWD_BYTES - 1)) st_nx = ST_POLL;
                end
                ST_CHK: begin
                    ack_nx = pwd_match;
                    if (!pwd_match)    st_nx = ST_REJECT;
                    else if (cmd_rd_q) st_nx = ST_READ;
                    else               st_nx = ST_WRITE;
                end
                ST_WRITE: begin
                    ack_nx = !wr_full;
                    if (wr_full) st_nx = ST_REJECT;
                end
                default: ack_nx = 1'b0;
            endcase
        end
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_ok    <= 1'b0;
            cmd_rd_q  <= 1'b0;
            cmd_sel_q <= 1'b0;
            sector_q  <= '0;
            pcnt_q    <= '0;
            wcnt_q    <= '0;
            wbuf_q    <= '0;
            rd_ptr    <= '0;
        end else begin
            if (in_start && st != ST_BUSY) ack_ok <= 1'b0;
            else if (byte_ev)              ack_ok <= ack_nx;

            if (st == ST_CMD && byte_ev && !in_start && !in_stop) begin
                cmd_rd_q  <= in_byte[7];
                cmd_sel_q <= in_byte[6];
                sector_q  <= in_byte[SW-1:0];
                pcnt_q    <= '0;
            end
            if (pwd_byte) pcnt_q <= pcnt_q + 1'b1;

            if (st == ST_CHK && byte_ev && pwd_match) begin
                rd_ptr <= AW'(sector_q) * AW'(SECT_BYTES);
                wcnt_q <= '0;
            end

            if (rd_adv) begin
                if (rd_ptr == AW'(DEPTH - 1)) rd_ptr <= '0;
                else                          rd_ptr <= rd_ptr + 1'b1;
            end

            if (st == ST_WRITE && byte_ev && !wr_full) begin
                for (int k = 0; k < SECT_BYTES; k++) begin
                    if (wcnt_q == CW'(k)) wbuf_q[k*8 +: 8] <= in_byte;
                end
                wcnt_q <= wcnt_q + 1'b1;
            end
        end
    end

    assign tx_valid = (st == ST_READ);
    assign tx_data  = tx_valid ? rd_data : 8'h00;

    // ---------------- sub-blocks ----------------
    pwmem_pwd_chk #(
        .PWD_BYTES (PWD_BYTES),
        .PWD_A     (PWD_A),
        .PWD_B     (PWD_B)
    ) u_pwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pwd_clear),
        .sel_b   (cmd_sel_q),
        .byte_v  (pwd_byte),
        .byte_in (in_byte),
        .idx     (pcnt_q),
        .match   (pwd_match)
    );

    pwmem_busy_tmr #(
        .CYCLES (WR_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .done  (tmr_done)
    );

    pwmem_array #(
        .SECTORS    (SECTORS),
        .SECT_BYTES (SECT_BYTES)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (rd_ptr),
        .rd_data   (rd_data),
        .wr_en     (commit),
        .wr_sector (sector_q),
        .wr_data   (wbuf_q)
    );

endmodule

// File: rtl/pwmem_slave_chk.sv
module pwmem_slave_chk
    import pwmem_pkg::*;
#(
    parameter int DEPTH      = 112,
    parameter int AW         = 7,
    parameter int CW         = 4,
    parameter int SECT_BYTES = 8
) (
    input logic          clk,
    input logic          rst_n,
    input pw_state_e     st,
    input logic          byte_ev,
    input logic          in_stop,
    input logic          ack_ok,
    input logic          rd_adv,
    input logic [AW-1:0] rd_ptr,
    input logic [CW-1:0] wcnt_q,
    input logic          commit,
    input logic          tx_valid
);
    p_reject_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REJECT && byte_ev) |=> !ack_ok);

    p_reject_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REJECT) |-> !tx_valid);

    p_busy_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && byte_ev) |=> !ack_ok);

    p_commit_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (st == ST_BUSY));

    p_read_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_adv && rd_ptr == AW'(DEPTH - 1)) |=> (rd_ptr == '0));

    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_ptr) < DEPTH);

    p_short_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE && in_stop && wcnt_q != CW'(SECT_BYTES)) |=> (st == ST_IDLE));

    p_overfill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE && byte_ev && !in_stop && wcnt_q == CW'(SECT_BYTES)) |=> (st == ST_REJECT));
endmodule

bind pwmem_slave pwmem_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .byte_ev  (byte_ev),
    .in_stop  (in_stop),
    .ack_ok   (ack_ok),
    .rd_adv   (rd_adv),
    .rd_ptr   (rd_ptr),
    .wcnt_q   (wcnt_q),
    .commit   (commit),
    .tx_valid (tx_valid)
);

// File: tb/pwmem_slave_bench.sv
module pwmem_slave_bench;
    localparam int SECTORS = 14;
    localparam int SB      = 8;
    localparam int DEPTH   = SECTORS * SB;
    localparam int WR      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_start = 1'b0, in_stop = 1'b0, in_byte_valid = 1'b0, in_rd_next = 1'b0;
    logic [7:0] in_byte = '0;
    logic       ack_ok, tx_valid;
    logic [7:0] tx_data;

    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;
    logic [7:0] exp_mem [DEPTH];

    always #2 clk = ~clk;

    pwmem_slave u_pwmem_slave (
        .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_stop(in_stop),
        .in_byte_valid(in_byte_valid), .in_byte(in_byte), .in_rd_next(in_rd_next),
        .ack_ok(ack_ok), .tx_valid(tx_valid), .tx_data(tx_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        in_start = 1'b1; @(negedge clk); in_start = 1'b0;
    endtask

    task automatic do_stop();
        in_stop = 1'b1; @(negedge clk); in_stop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b, input bit exp_ack, input string req);
        in_byte_valid = 1'b1; in_byte = b;
        @(negedge clk);
        in_byte_valid = 1'b0;
        chk(ack_ok == exp_ack, req, ack_ok, exp_ack);
    endtask

    task automatic rd_step();
        in_rd_next = 1'b1; @(negedge clk); in_rd_next = 1'b0;
    endtask

    // command, password, polling start and poll byte
    task automatic open_acc(input bit rd, input bit sel, input int sec, input bit bad_pw, input string req);
        do_start();
        xfer({rd, sel, 6'(sec)}, 1'b1, "R2");
        for (int k = 0; k < 8; k++)
            xfer((bad_pw && k == 3) ? 8'h01 : 8'h00, 1'b1, "R3");
        do_start();
        xfer(8'hC0, !bad_pw, req);
    endtask

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'((s * 8 + i) * 37 + 5);
    endfunction

    task automatic read_sector(input int s, input bit sel, input string req);
        open_acc(1'b1, sel, s, 1'b0, "R4");
        chk(tx_valid == 1'b1, req, tx_valid, 1);
        for (int i = 0; i < SB; i++) begin
            chk(tx_data == exp_mem[s*SB+i], req, tx_data, exp_mem[s*SB+i]);
            rd_step();
        end
        do_stop();
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'h00;
        idle(3);
        // R1: reset state
        chk(ack_ok == 1'b0, "R1", ack_ok, 0);
        chk(tx_valid == 1'b0, "R1", tx_valid, 0);
        chk(tx_data == 8'h00, "R1", tx_data, 0);
        rst_n = 1'b1;
        idle(2);
        read_sector(0, 1'b0, "R1");
        read_sector(13, 1'b1, "R1");

        // R8/R10: write every sector, alternate passwords
        for (int s = 0; s < SECTORS; s++) begin
            open_acc(1'b0, s[0], s, 1'b0, "R4");
            for (int i = 0; i < SB; i++) xfer(pat(s, i), 1'b1, "R8");
            do_stop();
            if (s == 0) begin
                do_start();
                xfer(8'h80, 1'b0, "R10");     // command during busy
                xfer(8'h00, 1'b0, "R10");
            end
            idle(WR + 4);
            for (int i = 0; i < SB; i++) exp_mem[s*SB+i] = pat(s, i);
        end
        // R6: read sweep
        for (int s = 0; s < SECTORS; s++) read_sector(s, !s[0], "R6");

        // R7: wrap from byte 111 to byte 0
        open_acc(1'b1, 1'b0, 13, 1'b0, "R4");
        for (int k = 0; k < 2*SB; k++) begin
            chk(tx_data == exp_mem[(13*SB + k) % DEPTH], "R7", tx_data, exp_mem[(13*SB + k) % DEPTH]);
            rd_step();
        end
        do_stop();

        // R2: out-of-range sectors
        do_start();
        xfer(8'h0E, 1'b0, "R2");
        xfer(8'h00, 1'b0, "R2");
        do_stop();
        do_start();
        xfer(8'hBF, 1'b0, "R2");
        do_start();
        xfer(8'h00, 1'b0, "R2");
        do_stop();
        read_sector(2, 1'b0, "R2");

        // R5: wrong password
        open_acc(1'b1, 1'b0, 2, 1'b1, "R5");
        xfer(8'h00, 1'b0, "R5");
        chk(tx_valid == 1'b0, "R5", tx_valid, 0);
        do_start();
        xfer(8'hC0, 1'b0, "R5");
        do_stop();
        read_sector(2, 1'b1, "R5");

        // R4: poll byte without a repeated start
        do_start();
        xfer(8'h83, 1'b1, "R2");
        for (int k = 0; k < 8; k++) xfer(8'h00, 1'b1, "R3");
        xfer(8'hC0, 1'b0, "R4");
        chk(tx_valid == 1'b0, "R4", tx_valid, 0);
        do_start();
        xfer(8'hC0, 1'b1, "R4");
        chk(tx_data == exp_mem[3*SB], "R4", tx_data, exp_mem[3*SB]);
        do_stop();

        // R9: short write then immediate command is accepted
        open_acc(1'b0, 1'b0, 5, 1'b0, "R4");
        for (int i = 0; i < 5; i++) xfer(8'hEE, 1'b1, "R9");
        do_stop();
        do_start();
        xfer(8'h85, 1'b1, "R9");
        do_stop();
        idle(WR + 4);
        read_sector(5, 1'b0, "R9");

        // R8: ninth byte refused, write discarded
        open_acc(1'b0, 1'b1, 6, 1'b0, "R4");
        for (int i = 0; i < SB; i++) xfer(8'h11, 1'b1, "R8");
        xfer(8'h11, 1'b0, "R8");
        do_stop();
        idle(WR + 4);
        read_sector(6, 1'b0, "R8");

        // R11: start during read and during write
        open_acc(1'b1, 1'b0, 3, 1'b0, "R4");
        rd_step();
        rd_step();
        read_sector(4, 1'b0, "R11");
        open_acc(1'b0, 1'b0, 7, 1'b0, "R4");
        for (int i = 0; i < 3; i++) xfer(8'h99, 1'b1, "R11");
        do_start();
        xfer(8'h87, 1'b1, "R11");
        do_stop();
        idle(WR + 4);
        read_sector(7, 1'b1, "R11");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule